// File: doc/BRIEF.md
# Quaternary Symbol Serializer Sequencer

This block is the digital control path of a transmitter that sends a parallel word as a train of quaternary symbols, two data bits per symbol. Each symbol is a 2-bit select code that an analog stage outside the block uses to choose one of four line shapes: a steady low level, a steady high level, a rising ramp or a falling ramp. The block emits only the select code, a one-cycle strobe that marks the start of each symbol, and a busy flag.

The clock runs at twice the symbol rate, so one clock cycle is one half-symbol tick and every symbol is held for two cycles. A frame is started by the falling edge of a start strobe. The word on the data bus is captured a fixed number of ticks later. A few ticks after that, a pair counter walks through the captured word, least significant pair first. Delays that would fall between ticks are rounded up to the next tick. With the default 8-bit word the frame is four symbols. Word width, capture delay, stepping delay and ticks per symbol are parameters. The symbol map does not change with the word width.

Top module: `qsym_serializer`

## Requirements
- R1: The symbol code equals the 2-bit value of the pair it carries: 00 selects the low level, 01 the high level, 10 the rising ramp and 11 the falling ramp.
- R2: Symbol k of a frame carries data bits [2k+1:2k], so the least significant pair goes out first and bits [7:6] go out last.
- R3: A frame has exactly DATA_W/2 symbols (four by default). Each symbol is held for two clock cycles, and `sym_valid_o` is high only in the first cycle of each symbol.
- R4: The start edge counts at the first rising clock edge E0 where `start_i` is sampled low after being sampled high while the block is idle. `busy_o` is high from E0 on.
- R5: The data word is taken from `data_i` at edge E0+2. A change before that edge is sent. A change after that edge has no effect on the symbols.
- R6: The first symbol appears with its strobe at edge E0+4. Before that, `sym_o` stays 00 and `sym_valid_o` stays low.
- R7: At edge E0+12, after the last symbol has been held for a full symbol period, `busy_o` clears and `sym_o` returns to 00. `sym_o` is 00 whenever `busy_o` is low.
- R8: A falling edge of `start_i` while `busy_o` is high is ignored. The running frame is unchanged, and no new frame follows it.
- R9: While reset is asserted and immediately after it, `sym_o` is 00 and both `sym_valid_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the symbol rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Parallel word to serialize |
| start_i | input | 1 | Start strobe; its falling edge begins a frame |
| sym_o | output | 2 | Line shape select code |
| sym_valid_o | output | 1 | High in the first cycle of each symbol |
| busy_o | output | 1 | High while a frame is in progress |

## Verification
The hardest situation to reach is a second start edge landing in the middle of a running frame, together with a data bus that changes around the capture instant. The stimulus tasks can raise and drop `start_i` at a chosen tick inside a frame. They can also move `data_i` one tick before or one tick after the capture edge. The expected symbols then follow either the late value or the original value. Random words are mixed with these injections and with back-to-back frames, so the idle-to-busy handoff is also covered.

// File: rtl/qsym_pkg.sv
package qsym_pkg;

   // line shape select codes
   typedef enum logic [1:0] {
      SYM_LOW  = 2'b00,
      SYM_HIGH = 2'b01,
      SYM_RISE = 2'b10,
      SYM_FALL = 2'b11
   } sym_code_e;

   // frame sequencing phases
   typedef enum logic [1:0] {
      PH_IDLE = 2'b00,
      PH_WAIT = 2'b01,
      PH_SEND = 2'b10
   } phase_e;

   function automatic int unsigned width_of(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/qsym_start_det.sv
module qsym_start_det (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic fall_o
);

   logic start_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         start_q <= 1'b0;
      end else begin
         start_q <= start_i;
      end
   end

   // high on the previous edge, low now
   assign fall_o = start_q & ~start_i;

endmodule

// File: rtl/qsym_timer.sv
module qsym_timer
   import qsym_pkg::*;
#(
   parameter int unsigned NSYM     = 4,
   parameter int unsigned CAP_DLY  = 2,
   parameter int unsigned STEP_DLY = 4,
   parameter int unsigned TPS      = 2,
   localparam int unsigned IDX_W   = width_of(NSYM),
   localparam int unsigned TCNT_W  = width_of(STEP_DLY + 1),
   localparam int unsigned SUB_W   = width_of(TPS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             fall_i,
   output logic             cap_en_o,
   output logic             load_o,
   output logic [IDX_W-1:0] load_idx_o,
   output logic             finish_o,
   output logic             busy_o
);

   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NSYM - 1);
   localparam logic [SUB_W-1:0]  LAST_SUB = SUB_W'(TPS - 1);
   localparam logic [TCNT_W-1:0] CAP_T    = TCNT_W'(CAP_DLY);
   localparam logic [TCNT_W-1:0] STEP_T   = TCNT_W'(STEP_DLY);

   phase_e             phase_q, phase_d;
   logic [TCNT_W-1:0]  tcnt_q, tcnt_d;
   logic [SUB_W-1:0]   sub_q, sub_d;
   logic [IDX_W-1:0]   idx_q, idx_d;
   logic               sym_end;

   assign sym_end = (phase_q == PH_SEND) && (sub_q == LAST_SUB);

   always_comb begin
      phase_d    = phase_q;
      tcnt_d     = tcnt_q;
      sub_d      = sub_q;
      idx_d      = idx_q;
      cap_en_o   = 1'b0;
      load_o     = 1'b0;
      load_idx_o = '0;
      finish_o   = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (fall_i) begin
               phase_d = PH_WAIT;
               tcnt_d  = TCNT_W'(1);
            end
         end
         PH_WAIT: begin
            if (tcnt_q == CAP_T) begin
               cap_en_o = 1'b1;
            end
            if (tcnt_q == STEP_T) begin
               phase_d    = PH_SEND;
               load_o     = 1'b1;
               load_idx_o = '0;
               idx_d      = '0;
               sub_d      = '0;
            end else begin
               tcnt_d = tcnt_q + TCNT_W'(1);
            end
         end
         PH_SEND: begin
            if (sym_end) begin
               sub_d = '0;
               if (idx_q == LAST_IDX) begin
                  phase_d  = PH_IDLE;
                  finish_o = 1'b1;
               end else begin
                  idx_d      = idx_q + IDX_W'(1);
                  load_o     = 1'b1;
                  load_idx_o = idx_q + IDX_W'(1);
               end
            end else begin
               sub_d = sub_q + SUB_W'(1);
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         tcnt_q  <= '0;
         sub_q   <= '0;
         idx_q   <= '0;
      end else begin
         phase_q <= phase_d;
         tcnt_q  <= tcnt_d;
         sub_q   <= sub_d;
         idx_q   <= idx_d;
      end
   end

   assign busy_o = (phase_q != PH_IDLE);

endmodule

// File: rtl/qsym_hold.sv
module qsym_hold
   import qsym_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned NSYM  = DATA_W / 2,
   localparam int unsigned IDX_W = width_of(NSYM)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cap_en_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [IDX_W-1:0]  sel_i,
   output logic [1:0]        pair_o
);

   logic [DATA_W-1:0] hold_q;
   logic [1:0]        pairs [NSYM];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_q <= '0;
      end else if (cap_en_i) begin
         hold_q <= data_i;
      end
   end

   // slot k carries bits [2k+1:2k]
   for (genvar k = 0; k < NSYM; k++) begin : g_pair
      assign pairs[k] = hold_q[2*k+1 : 2*k];
   end

   if (NSYM == (1 << IDX_W)) begin : g_full_sel
      assign pair_o = pairs[sel_i];
   end else begin : g_part_sel
      always_comb begin
         pair_o = 2'b00;
         for (int k = 0; k < NSYM; k++) begin
            if (sel_i == IDX_W'(k)) pair_o = pairs[k];
         end
      end
   end

endmodule

// File: rtl/qsym_encoder.sv
module qsym_encoder
   import qsym_pkg::*;
(
   input  logic [1:0] pair_i,
   output sym_code_e  sym_o
);

   always_comb begin
      unique case (pair_i)
         2'b00:   sym_o = SYM_LOW;
         2'b01:   sym_o = SYM_HIGH;
         2'b10:   sym_o = SYM_RISE;
         default: sym_o = SYM_FALL;
      endcase
   end

endmodule

// File: rtl/qsym_serializer.sv
module qsym_serializer
   import qsym_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CAP_DLY  = 2,
   parameter int unsigned STEP_DLY = 4,
   parameter int unsigned TPS      = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] data_i,
   input  logic              start_i,
   output logic [1:0]        sym_o,
   output logic              sym_valid_o,
   output logic              busy_o
);

   localparam int unsigned NSYM  = DATA_W / 2;
   localparam int unsigned IDX_W = width_of(NSYM);

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("DATA_W must be even and at least 4");
   end
   if (CAP_DLY < 1 || CAP_DLY >= STEP_DLY) begin : g_bad_delay
      $error("need 1 <= CAP_DLY < STEP_DLY");
   end
   if (TPS < 2) begin : g_bad_tps
      $error("TPS must be at least 2");
   end

   logic             fall;
   logic             cap_en;
   logic             load;
   logic [IDX_W-1:0] load_idx;
   logic             finish;
   logic [1:0]       pair;
   sym_code_e        code;
   logic [1:0]       sym_q;
   logic             valid_q;

   qsym_start_det u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i),
      .fall_o  (fall)
   );

   qsym_timer #(
      .NSYM     (NSYM),
      .CAP_DLY  (CAP_DLY),
      .STEP_DLY (STEP_DLY),
      .TPS      (TPS)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fall_i     (fall),
      .cap_en_o   (cap_en),
      .load_o     (load),
      .load_idx_o (load_idx),
      .finish_o   (finish),
      .busy_o     (busy_o)
   );

   qsym_hold #(
      .DATA_W (DATA_W)
   ) u_hold (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cap_en_i (cap_en),
      .data_i   (data_i),
      .sel_i    (load_idx),
      .pair_o   (pair)
   );

   qsym_encoder u_enc (
      .pair_i (pair),
      .sym_o  (code)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sym_q   <= SYM_LOW;
         valid_q <= 1'b0;
      end else begin
         valid_q <= load;
         if (finish) begin
            sym_q <= SYM_LOW;
         end else if (load) begin
            sym_q <= code;
         end
      end
   end

   assign sym_o       = sym_q;
   assign sym_valid_o = valid_q;

endmodule

// File: rtl/qsym_serializer_chk.sv
module qsym_serializer_chk #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned STEP_DLY = 4,
   parameter int unsigned TPS      = 2
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [1:0] sym_o,
   input logic       sym_valid_o,
   input logic       busy_o
);

   localparam int unsigned NSYM  = DATA_W / 2;
   localparam int unsigned FRAME = STEP_DLY + NSYM * TPS;
   localparam int unsigned CW    = $clog2(FRAME + 2) + 1;

   logic [CW-1:0] wcnt;
   logic [CW-1:0] vcnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wcnt <= '0;
         vcnt <= '0;
      end else begin
         wcnt <= busy_o ? wcnt + CW'(1) : '0;
         vcnt <= !busy_o ? '0 : (sym_valid_o ? vcnt + CW'(1) : vcnt);
      end
   end

   // R9
   reset_idle_chk: assert property (@(posedge clk_i) !rst_ni |=> (sym_o == 2'b00 && !sym_valid_o && !busy_o));

   // R7
   idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_o |-> sym_o == 2'b00);

   // R3
   strobe_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) sym_valid_o |-> busy_o);

   // R3
   strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) sym_valid_o |=> !sym_valid_o);

   // R3
   sym_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sym_o != $past(sym_o)) |-> (sym_valid_o || $fell(busy_o)));

   // R3
   symbol_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy_o) |-> vcnt == CW'(NSYM));

   // R6
   first_symbol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sym_valid_o && vcnt == '0) |-> wcnt == CW'(STEP_DLY));

   // R7
   frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy_o) |-> wcnt == CW'(FRAME));

endmodule

bind qsym_serializer qsym_serializer_chk #(
   .DATA_W   (DATA_W),
   .STEP_DLY (STEP_DLY),
   .TPS      (TPS)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .sym_o       (sym_o),
   .sym_valid_o (sym_valid_o),
   .busy_o      (busy_o)
);

// File: tb/tb_qsym_serializer.sv
module tb_qsym_serializer;

   localparam int CLK_PERIOD = 10;

   logic       clk;
   logic       rst_n;
   logic [7:0] data;
   logic       start;
   logic [1:0] sym;
   logic       valid;
   logic       busy;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   qsym_serializer dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .data_i      (data),
      .start_i     (start),
      .sym_o       (sym),
      .sym_valid_o (valid),
      .busy_o      (busy)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // expected symbol after edge E0+c (R1, R2, R6, R7)
   function automatic logic [1:0] exp_sym(input logic [7:0] d, input int c);
      if (c < 4 || c >= 12) return 2'b00;
      return d[2*((c-4)/2) +: 2];
   endfunction

   function automatic logic exp_valid(input int c);
      return (c == 4 || c == 6 || c == 8 || c == 10);
   endfunction

   function automatic logic exp_busy(input int c);
      return (c < 12);
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // mode: 0 plain, 1 data changes before capture, 2 data changes after capture,
   // 3 extra start edge in mid-frame
   task automatic run_frame(input logic [7:0] d, input int mode, input logic [7:0] alt);
      logic [7:0] sent;
      sent = (mode == 1) ? alt : d;
      @(negedge clk);
      data  = d;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(posedge clk);  // E0
      #1;
      chk("R4 busy at E0", {7'd0, busy}, 8'd1);
      chk("R6 sym before first symbol", {6'd0, sym}, 8'd0);
      for (int c = 1; c <= 12; c++) begin
         if (mode == 1 && c == 1) data = alt;
         if (mode == 3 && c == 5) start = 1'b1;
         if (mode == 3 && c == 6) start = 1'b0;
         @(posedge clk);
         #1;
         if (mode == 2 && c == 2) data = alt;
         chk((mode == 0) ? "R1/R2 sym" : (mode == 3 ? "R8 sym" : "R5 sym"),
             {6'd0, sym}, {6'd0, exp_sym(sent, c)});
         chk("R3 valid", {7'd0, valid}, {7'd0, exp_valid(c)});
         chk("R7 busy", {7'd0, busy}, {7'd0, exp_busy(c)});
      end
      if (mode == 3) begin
         for (int c = 0; c < 4; c++) begin
            @(posedge clk);
            #1;
            chk("R8 no second frame", {7'd0, busy}, 8'd0);
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0721));
      rst_n = 1'b0;
      data  = 8'h00;
      start = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R9
      chk("R9 sym in reset", {6'd0, sym}, 8'd0);
      chk("R9 valid in reset", {7'd0, valid}, 8'd0);
      chk("R9 busy in reset", {7'd0, busy}, 8'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R9 busy after reset", {7'd0, busy}, 8'd0);

      // R1 every code in order, then reversed
      run_frame(8'hE4, 0, 8'h00);
      run_frame(8'h1B, 0, 8'h00);
      run_frame(8'h00, 0, 8'h00);
      run_frame(8'hFF, 0, 8'h00);
      // R5 capture timing
      run_frame(8'h00, 1, 8'hB1);
      run_frame(8'h93, 2, 8'h6C);
      // R8 start while busy
      run_frame(8'h2D, 3, 8'h00);

      for (int i = 0; i < 24; i++) begin
         logic [7:0] d;
         logic [7:0] a;
         int m;
         d = 8'($urandom);
         a = 8'($urandom);
         m = int'($urandom % 4);
         run_frame(d, m, a);
         if (($urandom % 2) == 0) begin
            repeat (int'($urandom % 5)) begin
               @(posedge clk);
               #1;
               chk("R7 idle sym", {6'd0, sym}, 8'd0);
            end
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule